// File: doc/BRIEF.md
# Drift-Compensated Precision Time Counter

This block keeps a nanosecond time-of-day count for precision time protocol hardware. It runs from a free-running reference oscillator whose rate need not be a whole multiple of the wanted tick rate. On each oscillator cycle a 32-bit phase accumulator adds a programmable step value (the addend). Every carry out of that addition is one tick. Each tick advances a 64-bit time counter by a programmable period in nanoseconds.

The addend sets the tick rate as a fraction of the oscillator rate: addend = ceil(2^32 / (f_osc / f_tick)). Trimming the addend by a few counts corrects oscillator drift without disturbing the count. The fractional remainder stays in the accumulator, so no phase is lost across carries or across addend changes.

A prescaler divides the tick stream into a square-wave recovered clock for an output pin. Software sets up the block through a word-wide write port. The accumulator and the time counter are visible as output ports.

Top module: `drift_time_counter`

## Requirements
- R1: While reset is active and after its release, accOut, timeOut, tickPulse and clkOut are all zero. The period and addend are zero, the enable is off and the prescale value is 2.
- R2: On every clock edge with the enable set, the accumulator becomes (accumulator + addend) mod 2^32. The remainder is kept across carries.
- R3: When that 33-bit sum has its top bit set, tickPulse is high for the following cycle, and timeOut grows by the period on the same edge. Without a carry, timeOut holds.
- R4: Writing address 1 loads the period from data bits [9:0]. Data bits above bit 9 are ignored.
- R5: Writing address 2 loads the 32-bit addend. With addend 0xCCCC_CCCD (ratio 1.25), the first 5 enabled cycles give exactly 4 tick pulses, and 500 cycles give 400.
- R6: An addend write is used from the first clock edge after the write edge. The accumulated value is not cleared by it.
- R7: Writing address 0 sets the enable from data bit 0. While the enable is low, accOut, timeOut and clkOut hold and tickPulse stays low. Counting resumes from the held values when the enable is set again.
- R8: Writing address 3 loads the prescale value N from data bits [15:0], and N values of 0 or 1 act as 2. clkOut toggles on each N-th tick pulse, counted from reset, giving a square wave of 2N ticks per period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference oscillator clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register address: 0 enable, 1 period, 2 addend, 3 prescale |
| wrData | input | 32 | Register write data |
| accOut | output | 32 | Current phase accumulator value |
| timeOut | output | 64 | Nanosecond time counter |
| tickPulse | output | 1 | One-cycle pulse per accumulator carry |
| clkOut | output | 1 | Prescaled recovered clock |

## Verification
The hardest case to reach from the ports is an addend change in the middle of a run. The edge that stores the new addend still adds the old one. A design that clears the accumulator on the write, or that applies the new value one edge early, shows only a small change in accOut.

The bench reaches this case by running one cycle with a distinctive addend and writing a second addend while still enabled. It then checks accOut on the write edge and on the next edge, at values that expose both faults. A table of addend and period vectors covers the carry arithmetic. Separate runs at several prescale values count tick pulses between clkOut edges.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
  localparam int ACC_W    = 32;
  localparam int TIME_W   = 64;
  localparam int PERIOD_W = 10;
  localparam int PRSC_W   = 16;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 2;
  localparam int PRSC_MIN = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_ENABLE   = 2'd0,
    REG_PERIOD   = 2'd1,
    REG_ADDEND   = 2'd2,
    REG_PRESCALE = 2'd3
  } dtc_reg_e;

  // Strobes and settings handed from control to datapath
  typedef struct packed {
    logic                run;
    logic [PERIOD_W-1:0] period;
    logic [ACC_W-1:0]    addend;
    logic [PRSC_W-1:0]   divisor;
  } dtc_cfg_t;
endpackage

// File: rtl/dtc_ctrl.sv
module dtc_ctrl
  import dtc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output dtc_cfg_t          cfg
);
  logic                runQ;
  logic [PERIOD_W-1:0] periodQ;
  logic [ACC_W-1:0]    addendQ;
  logic [PRSC_W-1:0]   prscQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ    <= 1'b0;
      periodQ <= '0;
      addendQ <= '0;
      prscQ   <= PRSC_W'(PRSC_MIN);
    end else if (wrEn) begin
      unique case (dtc_reg_e'(wrAddr))
        REG_ENABLE:   runQ    <= wrData[0];
        REG_PERIOD:   periodQ <= wrData[PERIOD_W-1:0];
        REG_ADDEND:   addendQ <= wrData[ACC_W-1:0];
        REG_PRESCALE: prscQ   <= wrData[PRSC_W-1:0];
        default:      runQ    <= runQ;
      endcase
    end
  end

  always_comb begin
    cfg.run     = runQ;
    cfg.period  = periodQ;
    cfg.addend  = addendQ;
    cfg.divisor = (prscQ < PRSC_W'(PRSC_MIN)) ? PRSC_W'(PRSC_MIN) : prscQ;
  end
endmodule

// File: rtl/dtc_prescaler.sv
module dtc_prescaler
  import dtc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              run,
  input  logic              carry,
  input  logic [PRSC_W-1:0] divisor,
  output logic              clkOut
);
  logic [PRSC_W-1:0] cntQ;
  logic              clkQ;
  logic              lastTick;

  assign lastTick = (cntQ >= divisor - PRSC_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
      clkQ <= 1'b0;
    end else if (run && carry) begin
      if (lastTick) begin
        cntQ <= '0;
        clkQ <= ~clkQ;
      end else begin
        cntQ <= cntQ + PRSC_W'(1);
      end
    end
  end

  assign clkOut = clkQ;
endmodule

// File: rtl/dtc_datapath.sv
module dtc_datapath
  import dtc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dtc_cfg_t          cfg,
  output logic [ACC_W-1:0]  accOut,
  output logic [TIME_W-1:0] timeOut,
  output logic              tickPulse,
  output logic              clkOut
);
  logic [ACC_W-1:0]  accQ;
  logic [TIME_W-1:0] timeQ;
  logic              tickQ;
  logic [ACC_W:0]    sum;
  logic              carry;

  assign sum   = {1'b0, accQ} + {1'b0, cfg.addend};
  assign carry = sum[ACC_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ  <= '0;
      timeQ <= '0;
      tickQ <= 1'b0;
    end else if (cfg.run) begin
      accQ  <= sum[ACC_W-1:0];
      tickQ <= carry;
      if (carry) timeQ <= timeQ + TIME_W'(cfg.period);
    end else begin
      tickQ <= 1'b0;
    end
  end

  dtc_prescaler prsc_i (
    .clk     (clk),
    .rstN    (rstN),
    .run     (cfg.run),
    .carry   (carry),
    .divisor (cfg.divisor),
    .clkOut  (clkOut)
  );

  assign accOut    = accQ;
  assign timeOut   = timeQ;
  assign tickPulse = tickQ;
endmodule

// File: rtl/drift_time_counter.sv
module drift_time_counter
  import dtc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [ACC_W-1:0]  accOut,
  output logic [TIME_W-1:0] timeOut,
  output logic              tickPulse,
  output logic              clkOut
);
  dtc_cfg_t cfg;

  dtc_ctrl ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .cfg    (cfg)
  );

  dtc_datapath dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .cfg       (cfg),
    .accOut    (accOut),
    .timeOut   (timeOut),
    .tickPulse (tickPulse),
    .clkOut    (clkOut)
  );
endmodule

// File: rtl/dtc_checker.sv
module dtc_checker
  import dtc_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                run,
  input logic [PERIOD_W-1:0] period,
  input logic [ACC_W-1:0]    addend,
  input logic [ACC_W-1:0]    accOut,
  input logic [TIME_W-1:0]   timeOut,
  input logic                tickPulse,
  input logic                clkOut
);
  a_r2_acc_step: assert property (@(posedge clk) disable iff (!rstN)
    run |=> accOut == ACC_W'($past(accOut) + $past(addend)));

  a_r3_time_step: assert property (@(posedge clk) disable iff (!rstN)
    tickPulse |-> timeOut == $past(timeOut) + TIME_W'($past(period)));

  a_r3_time_still: assert property (@(posedge clk) disable iff (!rstN)
    !tickPulse |-> $stable(timeOut));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> ($stable(accOut) && $stable(timeOut) && $stable(clkOut) && !tickPulse));

  a_r8_toggle_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    (clkOut != $past(clkOut)) |-> tickPulse);
endmodule

bind drift_time_counter dtc_checker chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .run       (cfg.run),
  .period    (cfg.period),
  .addend    (cfg.addend),
  .accOut    (accOut),
  .timeOut   (timeOut),
  .tickPulse (tickPulse),
  .clkOut    (clkOut)
);

// File: tb/drift_time_counter_tb_top.sv
`timescale 1ns/1ps
module drift_time_counter_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] accOut;
  logic [63:0] timeOut;
  logic        tickPulse;
  logic        clkOut;

  int  nTests = 0;
  int  nFail  = 0;
  bit  done   = 1'b0;

  always #2 clk = ~clk;

  drift_time_counter dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .accOut(accOut), .timeOut(timeOut), .tickPulse(tickPulse), .clkOut(clkOut)
  );

  typedef struct packed {
    logic [31:0] addend;
    logic [31:0] periodRaw;
    logic [15:0] cycles;
    logic [31:0] expAcc;
    logic [63:0] expTime;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{32'hCCCC_CCCD, 32'd25,        16'd5,   32'h0000_0001, 64'd100},
    '{32'h8000_0000, 32'd8,         16'd7,   32'h8000_0000, 64'd24},
    '{32'hFFFF_FFFF, 32'h0000_03FF, 16'd3,   32'hFFFF_FFFD, 64'd2046},
    '{32'h0000_0000, 32'd5,         16'd10,  32'h0000_0000, 64'd0},
    '{32'h4000_0000, 32'h0000_040A, 16'd9,   32'h4000_0000, 64'd20},
    '{32'hCCCC_CCCD, 32'd25,        16'd500, 32'h0000_0064, 64'd10000}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    wrEn = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  // called at a negedge; the register updates on the next posedge
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic prscRun(input bit setIt, input logic [31:0] raw, input int expDiv, input string req);
    int cnt = 0;
    int toggles = 0;
    logic last;
    doReset();
    wr(2'd2, 32'hFFFF_FFFF);
    if (setIt) wr(2'd3, raw);
    wr(2'd0, 32'd1);
    last = clkOut;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (tickPulse) cnt++;
      if (clkOut !== last) begin
        check(req, 64'(cnt), 64'(expDiv));
        cnt = 0;
        toggles++;
        last = clkOut;
      end
    end
    check(req, 64'(toggles > 3), 64'd1);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      nFail++;
      nTests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] savedAcc;
    logic [63:0] savedTime;
    logic        savedClk;
    int          pulses;

    // R1: reset state
    @(negedge clk);
    doReset();
    check("R1 acc", 64'(accOut), 64'd0);
    check("R1 time", timeOut, 64'd0);
    check("R1 tick", 64'(tickPulse), 64'd0);
    check("R1 clkOut", 64'(clkOut), 64'd0);

    // R2 R3 R4 R5: vector table
    for (int v = 0; v < NVEC; v++) begin
      doReset();
      wr(2'd1, VECS[v].periodRaw);
      wr(2'd2, VECS[v].addend);
      wr(2'd0, 32'd1);
      repeat (int'(VECS[v].cycles)) @(negedge clk);
      check("R2 accumulator", 64'(accOut), 64'(VECS[v].expAcc));
      check("R3 R4 time", timeOut, VECS[v].expTime);
    end

    // R5: 4 pulses per 5 cycles at ratio 1.25
    doReset();
    wr(2'd1, 32'd25);
    wr(2'd2, 32'hCCCC_CCCD);
    wr(2'd0, 32'd1);
    pulses = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (tickPulse) pulses++;
    end
    check("R5 pulses per 5", 64'(pulses), 64'd4);
    for (int i = 0; i < 495; i++) begin
      @(negedge clk);
      if (tickPulse) pulses++;
    end
    check("R5 pulses per 500", 64'(pulses), 64'd400);

    // R6: addend change mid-run
    doReset();
    wr(2'd2, 32'h3000_0000);
    wr(2'd0, 32'd1);
    @(negedge clk);
    check("R6 before change", 64'(accOut), 64'h3000_0000);
    wr(2'd2, 32'h1000_0000);
    check("R6 old addend on write edge", 64'(accOut), 64'h6000_0000);
    @(negedge clk);
    check("R6 new addend, no clear", 64'(accOut), 64'h7000_0000);

    // R7: enable low holds state
    doReset();
    wr(2'd1, 32'd7);
    wr(2'd2, 32'h1234_5678);
    wr(2'd0, 32'd1);
    repeat (20) @(negedge clk);
    wr(2'd0, 32'd0);
    savedAcc = accOut; savedTime = timeOut; savedClk = clkOut;
    repeat (10) @(negedge clk);
    check("R7 acc holds", 64'(accOut), 64'(savedAcc));
    check("R7 time holds", timeOut, savedTime);
    check("R7 clkOut holds", 64'(clkOut), 64'(savedClk));
    check("R7 no tick", 64'(tickPulse), 64'd0);
    wr(2'd0, 32'd1);
    @(negedge clk);
    check("R7 resume", 64'(accOut), 64'(savedAcc + 32'h1234_5678));

    // R8 and R1: prescaler
    prscRun(1'b0, 32'd0, 2, "R1 R8 reset prescale");
    prscRun(1'b1, 32'd3, 3, "R8 prescale 3");
    prscRun(1'b1, 32'd0, 2, "R8 prescale 0");
    prscRun(1'b1, 32'd1, 2, "R8 prescale 1");
    prscRun(1'b1, 32'hFFFF_0005, 5, "R8 prescale 5");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule